// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings SDRAM out of power-up through the standard bring-up steps, and a memory controller uses it before it begins ordinary traffic. A one-cycle start pulse captures the requested CAS latency and the set of populated memory rows. The block then waits for power and clocks to settle, and issues a NOP, a precharge-all, a run of auto-refresh commands and a mode-register load, with a wait after each one. It ends by returning the controller to normal mode and turning on periodic refresh. A done flag follows.

Each command except normal mode is sent to the rows one at a time, in row order, with one clock per row. A row that is not populated is passed over: its clock slot still elapses, but no chip select is driven for it. The mode-register word is built from the captured CAS latency and from burst parameters fixed at build time. All waits are parameters counted in controller clocks. The stabilization wait is derived from the clock frequency and the time in microseconds.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is held, and afterwards until the first start, the outputs are: `cmd_o` = 1 (NOP), `cs_o` = 0, `mode_addr_o` = 0, `refresh_en_o` = 0, `done_o` = 0.
- R2: `cmd_o` only ever carries one of five codes: 0 normal, 1 NOP, 2 precharge-all, 3 mode-register load, 4 auto-refresh. The values 5, 6 and 7 never appear.
- R3: After a valid start, the block waits `CLK_MHZ*STAB_US` cycles with `cmd_o` = 1 and no chip select before it issues any command.
- R4: An issue phase lasts `NUM_ROWS` cycles. In cycle k of the phase, `cs_o` equals `1<<k` when bit k of the row mask captured at start is set, and 0 when it is not. Changes to `row_present_i` after start have no effect.
- R5: The NOP issue phase is followed by `NOP_CYC` cycles of wait. The precharge issue phase (code 2) comes next, followed by `TRP_CYC` cycles of wait.
- R6: Exactly `REFRESH_COUNT` auto-refresh issue phases (code 4) follow, each one followed by `TRC_CYC` cycles of wait.
- R7: During the mode-register issue phase (code 3), `mode_addr_o` = burst length code in bits 2:0, burst type in bit 3, CAS latency in bits 6:4, zero in bits 8:7, write-burst mode in bit 9 and zero in bits 11:10. At every other time `mode_addr_o` is 0.
- R8: The mode-register issue phase is followed by `MRS_CYC` wait cycles with code 3. Then comes exactly one cycle of code 0 with refresh off, and then `refresh_en_o` rises.
- R9: `done_o` rises one cycle after `refresh_en_o` rises. Both then stay high until the next start or reset.
- R10: A start with a CAS latency other than 2 or 3 puts the block in an error state with `cmd_o` = 1, `cs_o` = 0, `refresh_en_o` = 0 and `done_o` = 0. It stays there until the next start.
- R11: A start in any state, including the middle of a sequence, restarts the sequence from the stabilization wait with the newly captured CAS latency and row mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle pulse that launches or restarts the sequence |
| cas_lat_i | input | 3 | Requested CAS latency, captured at start |
| row_present_i | input | NUM_ROWS | Populated-row mask, captured at start |
| cmd_o | output | 3 | Current command code |
| mode_addr_o | output | 12 | Mode-register word during the mode-register issue phase |
| cs_o | output | NUM_ROWS | Per-row chip select, at most one bit set |
| refresh_en_o | output | 1 | Periodic refresh enable |
| done_o | output | 1 | Initialization complete |

## Verification
The bench builds the block with four rows, a 20 MHz clock setting and a 1 µs stabilization time, which gives a 20-cycle settle. The NOP, tRP, tRC and mode-register waits are 12, 3, 5 and 2 cycles, and eight refreshes are kept. With these values a full bring-up takes about 130 cycles. That is short enough to run every one of the sixteen row masks, both CAS values, the invalid CAS codes and mid-sequence restarts, and to compare every output against a timeline model on every cycle.

// File: rtl/sdinit_pkg.sv
package sdinit_pkg;

  localparam int MODE_W = 12;

  typedef enum logic [2:0] {
    CMD_NORMAL    = 3'd0,
    CMD_NOP       = 3'd1,
    CMD_PRECHARGE = 3'd2,
    CMD_MRS       = 3'd3,
    CMD_REFRESH   = 3'd4
  } sd_cmd_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_STAB, ST_NOP_ISS, ST_NOP_WAIT, ST_PRE_ISS, ST_PRE_WAIT,
    ST_REF_ISS, ST_REF_WAIT, ST_MRS_ISS, ST_MRS_WAIT, ST_NORMAL,
    ST_REF_ON, ST_DONE, ST_ERR
  } seq_state_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic cas_ok(input logic [2:0] cas);
    return (cas == 3'd2) || (cas == 3'd3);
  endfunction

  // Mode word: [2:0] burst length, [3] burst type, [6:4] CAS, [9] write burst
  function automatic logic [MODE_W-1:0] mode_word(input logic [2:0] cas,
                                                  input logic [2:0] blen,
                                                  input logic       btype,
                                                  input logic       wsingle);
    return {2'b00, wsingle, 2'b00, cas, btype, blen};
  endfunction

endpackage

// File: rtl/sdinit_timer.sv
module sdinit_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (load)          cnt <= load_val - 1'b1;
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

  AST_LOAD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (load_val != '0)); // R3

  AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && $past(!load) && cnt != '0) |=> (cnt == $past(cnt) - 1'b1)); // R5
endmodule

// File: rtl/sdinit_row_walk.sv
module sdinit_row_walk #(
  parameter int NUM_ROWS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                active,
  input  logic [NUM_ROWS-1:0] rows,
  output logic [NUM_ROWS-1:0] cs,
  output logic                last
);
  localparam int IW = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1;
  localparam logic [IW-1:0] LAST_IDX = IW'(NUM_ROWS - 1);

  logic [IW-1:0] idx;

  assign last = active && (idx == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              idx <= '0;
    else if (!active || last) idx <= '0;
    else                     idx <= idx + 1'b1;
  end

  for (genvar r = 0; r < NUM_ROWS; r++) begin : g_cs
    assign cs[r] = active && rows[r] && (idx == IW'(r));
  end

  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= LAST_IDX); // R4

  AST_CS_POPULATED: assert property (@(posedge clk) disable iff (!rst_n)
    (cs & ~rows) == '0); // R4
endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdinit_pkg::*;
#(
  parameter int          NUM_ROWS      = 4,
  parameter int          CLK_MHZ       = 100,
  parameter int          STAB_US       = 200,
  parameter int          NOP_CYC       = 200,
  parameter int          TRP_CYC       = 3,
  parameter int          TRC_CYC       = 9,
  parameter int          MRS_CYC       = 2,
  parameter int          REFRESH_COUNT = 8,
  parameter logic [2:0]  BURST_LEN     = 3'd2,
  parameter logic        BURST_TYPE    = 1'b1,
  parameter logic        WRITE_SINGLE  = 1'b0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [2:0]          cas_lat_i,
  input  logic [NUM_ROWS-1:0] row_present_i,
  output logic [2:0]          cmd_o,
  output logic [MODE_W-1:0]   mode_addr_o,
  output logic [NUM_ROWS-1:0] cs_o,
  output logic                refresh_en_o,
  output logic                done_o
);
  localparam int STAB_CYC = CLK_MHZ * STAB_US;
  localparam int MAX_WAIT = max2(max2(STAB_CYC, NOP_CYC),
                                 max2(max2(TRP_CYC, TRC_CYC), MRS_CYC));
  localparam int TW = $clog2(MAX_WAIT + 1);
  localparam int RW = (REFRESH_COUNT > 1) ? $clog2(REFRESH_COUNT) : 1;

  seq_state_e          state, nxt;
  logic [2:0]          cas_q;
  logic [NUM_ROWS-1:0] rows_q;
  logic [RW-1:0]       ref_cnt;
  logic                t_load, t_exp, w_last;
  logic [TW-1:0]       t_val;

  // named events for the assertions
  logic issue_w, err_w, ref_last_w;
  assign issue_w    = (state == ST_NOP_ISS) || (state == ST_PRE_ISS) ||
                      (state == ST_REF_ISS) || (state == ST_MRS_ISS);
  assign err_w      = (state == ST_ERR);
  assign ref_last_w = (ref_cnt == RW'(REFRESH_COUNT - 1));

  sdinit_timer #(.W(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .expired(t_exp)
  );

  sdinit_row_walk #(.NUM_ROWS(NUM_ROWS)) u_walk (
    .clk(clk), .rst_n(rst_n), .active(issue_w), .rows(rows_q),
    .cs(cs_o), .last(w_last)
  );

  always_comb begin
    nxt    = state;
    t_load = 1'b0;
    t_val  = '0;
    if (start_i) begin
      if (cas_ok(cas_lat_i)) begin
        nxt = ST_STAB; t_load = 1'b1; t_val = TW'(STAB_CYC);
      end else begin
        nxt = ST_ERR;
      end
    end else begin
      case (state)
        ST_STAB:     if (t_exp) nxt = ST_NOP_ISS;
        ST_NOP_ISS:  if (w_last) begin nxt = ST_NOP_WAIT; t_load = 1'b1; t_val = TW'(NOP_CYC); end
        ST_NOP_WAIT: if (t_exp) nxt = ST_PRE_ISS;
        ST_PRE_ISS:  if (w_last) begin nxt = ST_PRE_WAIT; t_load = 1'b1; t_val = TW'(TRP_CYC); end
        ST_PRE_WAIT: if (t_exp) nxt = ST_REF_ISS;
        ST_REF_ISS:  if (w_last) begin nxt = ST_REF_WAIT; t_load = 1'b1; t_val = TW'(TRC_CYC); end
        ST_REF_WAIT: if (t_exp) nxt = ref_last_w ? ST_MRS_ISS : ST_REF_ISS;
        ST_MRS_ISS:  if (w_last) begin nxt = ST_MRS_WAIT; t_load = 1'b1; t_val = TW'(MRS_CYC); end
        ST_MRS_WAIT: if (t_exp) nxt = ST_NORMAL;
        ST_NORMAL:   nxt = ST_REF_ON;
        ST_REF_ON:   nxt = ST_DONE;
        default:     nxt = state;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cas_q   <= '0;
      rows_q  <= '0;
      ref_cnt <= '0;
    end else begin
      state <= nxt;
      if (start_i) begin
        cas_q   <= cas_lat_i;
        rows_q  <= row_present_i;
        ref_cnt <= '0;
      end else if (state == ST_REF_WAIT && t_exp && !ref_last_w) begin
        ref_cnt <= ref_cnt + 1'b1;
      end
    end
  end

  always_comb begin
    case (state)
      ST_PRE_ISS, ST_PRE_WAIT:                   cmd_o = CMD_PRECHARGE;
      ST_REF_ISS, ST_REF_WAIT:                   cmd_o = CMD_REFRESH;
      ST_MRS_ISS, ST_MRS_WAIT:                   cmd_o = CMD_MRS;
      ST_NORMAL, ST_REF_ON, ST_DONE:             cmd_o = CMD_NORMAL;
      default:                                   cmd_o = CMD_NOP;
    endcase
  end

  assign mode_addr_o  = (state == ST_MRS_ISS) ?
                        mode_word(cas_q, BURST_LEN, BURST_TYPE, WRITE_SINGLE) : '0;
  assign refresh_en_o = (state == ST_REF_ON) || (state == ST_DONE);
  assign done_o       = (state == ST_DONE);

  AST_CMD_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_o <= 3'd4); // R2

  AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cs_o)); // R4

  AST_CS_ONLY_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_o != '0) |-> (cmd_o != CMD_NORMAL)); // R4

  AST_MODE_ONLY_MRS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_addr_o != '0) |-> (cmd_o == CMD_MRS)); // R7

  AST_REF_AFTER_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(refresh_en_o) && !$past(start_i)) |-> ($past(cmd_o) == CMD_NORMAL)); // R8

  AST_DONE_AFTER_REF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(refresh_en_o)); // R9

  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    err_w |-> (!done_o && !refresh_en_o && cs_o == '0)); // R10

  AST_START_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && cas_ok(cas_lat_i)) |=> (cmd_o == CMD_NOP && cs_o == '0 && !done_o)); // R11
endmodule

// File: tb/sdram_init_seq_test.sv
module sdram_init_seq_test;
  localparam int N     = 4;
  localparam int MHZ   = 20;
  localparam int US    = 1;
  localparam int S     = MHZ * US;
  localparam int NW    = 12;
  localparam int TRP   = 3;
  localparam int TRC   = 5;
  localparam int MRSW  = 2;
  localparam int NREF  = 8;
  localparam int SEQ_L = S + N + NW + N + TRP + NREF * (N + TRC) + N + MRSW + 2;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_i = 1'b0;
  logic [2:0]   cas_lat_i = 3'd0;
  logic [N-1:0] row_present_i = '0;
  logic [2:0]   cmd_o;
  logic [11:0]  mode_addr_o;
  logic [N-1:0] cs_o;
  logic         refresh_en_o, done_o;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  sdram_init_seq #(
    .NUM_ROWS(N), .CLK_MHZ(MHZ), .STAB_US(US), .NOP_CYC(NW), .TRP_CYC(TRP),
    .TRC_CYC(TRC), .MRS_CYC(MRSW), .REFRESH_COUNT(NREF),
    .BURST_LEN(3'd2), .BURST_TYPE(1'b1), .WRITE_SINGLE(1'b0)
  ) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cas_lat_i(cas_lat_i),
    .row_present_i(row_present_i), .cmd_o(cmd_o), .mode_addr_o(mode_addr_o),
    .cs_o(cs_o), .refresh_en_o(refresh_en_o), .done_o(done_o)
  );

  function automatic logic [11:0] exp_mode(input int cas);
    return 12'(2 + 1 * 8 + cas * 16 + 0 * 512);
  endfunction

  function automatic logic [N-1:0] row_sel(input logic [N-1:0] r, input int k);
    return r[k] ? (N'(1) << k) : '0;
  endfunction

  // expected outputs t cycles after the start pulse was captured
  function automatic void expect_at(input int t, input logic [N-1:0] r, input int cas,
                                    output logic [2:0] c, output logic [N-1:0] s,
                                    output logic [11:0] m, output logic re,
                                    output logic dn, output string tag);
    int q = t;
    c = 3'd1; s = '0; m = '0; re = 1'b0; dn = 1'b0; tag = "R3";
    if (q < S) return;
    q -= S;
    tag = "R4"; if (q < N) begin s = row_sel(r, q); return; end
    q -= N;
    tag = "R5"; if (q < NW) return;
    q -= NW;
    c = 3'd2;
    tag = "R4"; if (q < N) begin s = row_sel(r, q); return; end
    q -= N;
    tag = "R5"; if (q < TRP) return;
    q -= TRP;
    c = 3'd4;
    for (int k = 0; k < NREF; k++) begin
      tag = "R6"; if (q < N) begin s = row_sel(r, q); return; end
      q -= N;
      if (q < TRC) return;
      q -= TRC;
    end
    c = 3'd3;
    tag = "R7"; if (q < N) begin s = row_sel(r, q); m = exp_mode(cas); return; end
    q -= N;
    tag = "R8"; if (q < MRSW) return;
    q -= MRSW;
    c = 3'd0;
    if (q == 0) return;
    re = 1'b1;
    if (q == 1) return;
    dn = 1'b1; tag = "R9";
  endfunction

  task automatic compare(input string tag, input logic [2:0] c, input logic [N-1:0] s,
                         input logic [11:0] m, input logic re, input logic dn);
    checks++;
    if (cmd_o !== c || cs_o !== s || mode_addr_o !== m ||
        refresh_en_o !== re || done_o !== dn) begin
      errors++;
      $display("FAIL %s t=%0t actual cmd=%0d cs=%b mode=%h ref=%b done=%b expected cmd=%0d cs=%b mode=%h ref=%b done=%b",
               tag, $time, cmd_o, cs_o, mode_addr_o, refresh_en_o, done_o, c, s, m, re, dn);
    end
  endtask

  // pulse start at a falling edge; returns at the falling edge after capture
  task automatic launch(input logic [N-1:0] r, input logic [2:0] cas);
    start_i = 1'b1; cas_lat_i = cas; row_present_i = r;
    @(negedge clk);
    start_i = 1'b0;
    row_present_i = N'($urandom);   // R4: later changes must not matter
    cas_lat_i = 3'($urandom);
  endtask

  task automatic check_run(input logic [N-1:0] r, input int cas, input int cycles,
                           input string over);
    logic [2:0] c; logic [N-1:0] s; logic [11:0] m; logic re, dn; string tag;
    for (int t = 0; t < cycles; t++) begin
      expect_at(t, r, cas, c, s, m, re, dn, tag);
      compare((over != "") ? over : tag, c, s, m, re, dn);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    compare("R1", 3'd1, '0, '0, 1'b0, 1'b0);       // R1 during reset
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    compare("R1", 3'd1, '0, '0, 1'b0, 1'b0);       // R1 after reset, no start
    row_present_i = '1;                             // R1: inputs without start ignored
    cas_lat_i = 3'd3;
    repeat (4) @(negedge clk);
    compare("R1", 3'd1, '0, '0, 1'b0, 1'b0);

    // R4 R5 R6 R7 R8 R9: every row mask, CAS picked at random
    for (int p = 0; p < (1 << N); p++) begin
      int cas = ($urandom % 2) ? 3 : 2;
      launch(N'(p), 3'(cas));
      check_run(N'(p), cas, SEQ_L + 4, "");
    end

    // directed corners: CAS 2 and 3 with full and empty masks
    launch('1, 3'd2); check_run('1, 2, SEQ_L + 2, "");
    launch('0, 3'd3); check_run('0, 3, SEQ_L + 2, "");

    // R10: invalid CAS values park the block
    for (int k = 0; k < 8; k++) begin
      if (k == 2 || k == 3) continue;
      launch(N'($urandom), 3'(k));
      for (int t = 0; t < 25; t++) begin
        compare("R10", 3'd1, '0, '0, 1'b0, 1'b0);
        @(negedge clk);
      end
    end

    // R11: valid start out of the error state
    launch(4'b1010, 3'd3); check_run(4'b1010, 3, SEQ_L + 2, "");

    // R11: restart mid-sequence with new CAS and mask
    for (int k = 0; k < 4; k++) begin
      logic [N-1:0] r1 = N'($urandom);
      int cas1 = ($urandom % 2) ? 3 : 2;
      int cut  = 1 + int'($urandom % (SEQ_L - 2));
      launch(N'($urandom), 3'(5 - cas1));
      repeat (cut) @(negedge clk);
      launch(r1, 3'(cas1));
      check_run(r1, cas1, SEQ_L + 2, "");
    end

    // R11: restart from done into an invalid CAS
    launch(4'b0011, 3'd6);
    compare("R11", 3'd1, '0, '0, 1'b0, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule